// File: doc/BRIEF.md
# SHA-224/SHA-256 Block Compression Engine

This engine hashes messages that arrive already padded and cut into 512-bit blocks. A message starts with a block-count token on its own valid/ready channel. The mode input is sampled together with that token. Then the stated number of blocks arrives on a second channel, one 32-bit word per handshake and sixteen words per block, most significant word first. The engine runs the compression function once for each block, with one round per cycle. The message schedule is produced on the fly from a rolling window of sixteen words. After each block the working variables are folded into the running hash state. When the last block is done, the digest is offered on a third valid/ready channel and held there until it is taken.

SHA-256 and SHA-224 share the whole datapath. The two modes differ only in the initial hash value loaded at the start of each message and in the truncation of the final digest. With words supplied without gaps, each block takes a fixed 68 cycles. That is one cycle to load the working variables, one cycle to pre-fetch the first schedule word, 64 rounds, one accumulate cycle and one block-end cycle. A new block never begins before the previous block's state update has finished.

Top module: `sha256Core`

## Requirements
- R1: After reset, cntReady is 1, wordReady is 0, digValid is 0 and digData is all zeros.
- R2: cntReady is 1 only when no message is in flight and no digest is waiting. While a message is being hashed or its digest is pending, no count token is accepted.
- R3: With modeSel=0 at the count handshake, the digest equals SHA-256 over the supplied blocks. digData[255:224] holds H0, and each following 32-bit lane holds the next state word, down to H7 in digData[31:0].
- R4: With modeSel=1 at the count handshake, the SHA-224 initial value is used. H0..H6 appear in digData[255:32] in the same order as R3, and digData[31:0] is zero.
- R5: The mode is captured only at the count handshake. Changing modeSel while a message is in flight has no effect on its digest.
- R6: Exactly 16 words are accepted per block, and 16*N words per message of N blocks.
- R7: With words always valid, a block spans 68 cycles. Call the count handshake edge E0. In the cycle after edge E0+68k+c, wordReady is high exactly for c in 1..16 (for k below N). digValid first reads high after edge E0+68N.
- R8: Gaps in wordValid stall the whole engine without changing the digest. The digest never appears earlier than the gap-free latency of R7.
- R9: digValid and digData stay unchanged until the digest handshake. The cycle after that handshake, digValid is 0 and cntReady is 1.
- R10: A count of zero makes the engine offer the initial hash value of the captured mode, truncated as in R4, in the cycle right after the count handshake.
- R11: The hash state is reloaded at the start of every message, so the same message always gives the same digest regardless of earlier messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 1 | 0 = SHA-256, 1 = SHA-224; sampled with the count token |
| cntValid | input | 1 | Block-count token offered |
| cntReady | output | 1 | Engine idle and able to take a count token |
| cntData | input | CNT_W | Number of 512-bit blocks in the message |
| wordValid | input | 1 | Message word offered |
| wordReady | output | 1 | Engine takes a message word this cycle |
| wordData | input | 32 | Message word, block order, most significant word first |
| digValid | output | 1 | Digest offered |
| digReady | input | 1 | Consumer takes the digest |
| digData | output | 256 | H0 in the top lane down to H7 (zero in SHA-224 mode) |

## Verification
The checker assumes that a producer keeps cntData, modeSel and wordData steady for the cycle in which it offers them. It also assumes the word stream carries exactly the number of words that the count token announced. Only then does the tally of accepted words per message mean anything. The bench keeps to this by design. It builds each message as a queue of 16*N words before sending the token, pops a word only on a handshake, and only changes modeSel after the token is taken. Word gaps are placed on fixed cycles, and the digest consumer holds off for a set number of cycles, so every stall pattern stays inside the handshake rules the checker relies on.

// File: rtl/sha256Pkg.sv
package sha256Pkg;

  localparam int WORD_W      = 32;
  localparam int ROUNDS      = 64;
  localparam int SCHED_DEPTH = 16;
  localparam int HASH_WORDS  = 8;
  localparam int DIG_W       = WORD_W * HASH_WORDS;
  localparam int IDX_W       = $clog2(ROUNDS);

  typedef logic [WORD_W-1:0] word_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic             loadIv;    // start of message: load initial hash value
    logic             ivSel;     // mode for loadIv (1 = SHA-224)
    logic             is224;     // captured mode of the message in flight
    logic             loadWork;  // copy running hash into working variables
    logic             fetch;     // produce one schedule word
    logic             useExt;    // schedule word comes from the input stream
    logic [IDX_W-1:0] fetchIdx;  // round index of the fetched word
    logic             round;     // run one compression round
    logic             accum;     // fold working variables into running hash
  } ctrlStrobe_t;

  localparam word_t ROUND_K [ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
    32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
    32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
    32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
    32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
    32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
    32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
    32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
    32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  localparam word_t IV_256 [HASH_WORDS] = '{
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
  };

  localparam word_t IV_224 [HASH_WORDS] = '{
    32'hc1059ed8, 32'h367cd507, 32'h3070dd17, 32'hf70e5939,
    32'hffc00b31, 32'h68581511, 32'h64f98fa7, 32'hbefa4fa4
  };

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

endpackage

// File: rtl/sha256Sched.sv
module sha256Sched
  import sha256Pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t stb,
  input  word_t       wordData,
  output word_t       kwSum
);

  word_t win [SCHED_DEPTH];
  word_t expWord;
  word_t newWord;

  // Window holds W[t-16] (index 0) up to W[t-1] (index SCHED_DEPTH-1)
  always_comb begin
    expWord = (rotr(win[SCHED_DEPTH-2], 17) ^ rotr(win[SCHED_DEPTH-2], 19) ^ (win[SCHED_DEPTH-2] >> 10))
            + win[SCHED_DEPTH-7]
            + (rotr(win[1], 7) ^ rotr(win[1], 18) ^ (win[1] >> 3))
            + win[0];
    newWord = stb.useExt ? wordData : expWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SCHED_DEPTH; i++) win[i] <= '0;
      kwSum <= '0;
    end else if (stb.fetch) begin
      for (int i = 0; i < SCHED_DEPTH - 1; i++) win[i] <= win[i+1];
      win[SCHED_DEPTH-1] <= newWord;
      kwSum <= ROUND_K[stb.fetchIdx] + newWord;
    end
  end

endmodule

// File: rtl/sha256Datapath.sv
module sha256Datapath
  import sha256Pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      stb,
  input  word_t            wordData,
  output logic [DIG_W-1:0] digest
);

  word_t kwSum;
  word_t hs [HASH_WORDS];
  word_t wv [HASH_WORDS];
  word_t bigS0, bigS1, chooseV, majV, tOne, tTwo;

  sha256Sched uSched (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wordData (wordData),
    .kwSum    (kwSum)
  );

  // One compression round: wv[0..7] = a..h
  always_comb begin
    bigS1   = rotr(wv[4], 6) ^ rotr(wv[4], 11) ^ rotr(wv[4], 25);
    chooseV = (wv[4] & wv[5]) ^ (~wv[4] & wv[6]);
    bigS0   = rotr(wv[0], 2) ^ rotr(wv[0], 13) ^ rotr(wv[0], 22);
    majV    = (wv[0] & wv[1]) ^ (wv[0] & wv[2]) ^ (wv[1] & wv[2]);
    tOne    = wv[7] + bigS1 + chooseV + kwSum;
    tTwo    = bigS0 + majV;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HASH_WORDS; i++) wv[i] <= '0;
    end else if (stb.loadWork) begin
      for (int i = 0; i < HASH_WORDS; i++) wv[i] <= hs[i];
    end else if (stb.round) begin
      wv[0] <= tOne + tTwo;
      wv[1] <= wv[0];
      wv[2] <= wv[1];
      wv[3] <= wv[2];
      wv[4] <= wv[3] + tOne;
      wv[5] <= wv[4];
      wv[6] <= wv[5];
      wv[7] <= wv[6];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HASH_WORDS; i++) hs[i] <= '0;
    end else if (stb.loadIv) begin
      for (int i = 0; i < HASH_WORDS; i++) hs[i] <= stb.ivSel ? IV_224[i] : IV_256[i];
    end else if (stb.accum) begin
      for (int i = 0; i < HASH_WORDS; i++) hs[i] <= hs[i] + wv[i];
    end
  end

  // Big-endian assembly, last lane dropped in truncated mode
  for (genvar gi = 0; gi < HASH_WORDS; gi++) begin : gLane
    if (gi == HASH_WORDS - 1) begin : gLast
      assign digest[WORD_W-1:0] = stb.is224 ? '0 : hs[gi];
    end else begin : gKeep
      assign digest[DIG_W-1-WORD_W*gi -: WORD_W] = hs[gi];
    end
  end

endmodule

// File: rtl/sha256Ctrl.sv
module sha256Ctrl
  import sha256Pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSel,
  input  logic             cntValid,
  output logic             cntReady,
  input  logic [CNT_W-1:0] cntData,
  input  logic             wordValid,
  output logic             wordReady,
  output logic             digValid,
  input  logic             digReady,
  output ctrlStrobe_t      stb
);

  localparam int FIRST_FETCH  = 1;
  localparam int LAST_FETCH   = FIRST_FETCH + ROUNDS - 1;
  localparam int FIRST_ROUND  = FIRST_FETCH + 1;
  localparam int LAST_ROUND   = FIRST_ROUND + ROUNDS - 1;
  localparam int ACC_CYC      = LAST_ROUND + 1;
  localparam int END_CYC      = ACC_CYC + 1;
  localparam int BLOCK_CYCLES = END_CYC + 1;
  localparam int CYC_W        = $clog2(BLOCK_CYCLES);

  localparam logic [CYC_W-1:0] C_FF  = CYC_W'(FIRST_FETCH);
  localparam logic [CYC_W-1:0] C_LF  = CYC_W'(LAST_FETCH);
  localparam logic [CYC_W-1:0] C_LW  = CYC_W'(FIRST_FETCH + SCHED_DEPTH - 1);
  localparam logic [CYC_W-1:0] C_FR  = CYC_W'(FIRST_ROUND);
  localparam logic [CYC_W-1:0] C_LR  = CYC_W'(LAST_ROUND);
  localparam logic [CYC_W-1:0] C_ACC = CYC_W'(ACC_CYC);
  localparam logic [CYC_W-1:0] C_END = CYC_W'(END_CYC);

  typedef enum logic [1:0] {ST_IDLE, ST_BLOCK, ST_OUT} state_t;

  state_t           state;
  logic [CYC_W-1:0] cyc;
  logic [CYC_W-1:0] cycRel;
  logic [CNT_W-1:0] blocksLeft;
  logic             is224Q;
  logic             inBlock;
  logic             needWord;
  logic             advance;
  logic             cntFire;

  always_comb begin
    inBlock   = (state == ST_BLOCK);
    needWord  = inBlock && (cyc >= C_FF) && (cyc <= C_LW);
    advance   = inBlock && (!needWord || wordValid);
    cntReady  = (state == ST_IDLE);
    wordReady = needWord;
    digValid  = (state == ST_OUT);
    cntFire   = cntReady && cntValid;
    cycRel    = cyc - C_FF;
  end

  always_comb begin
    stb          = '0;
    stb.loadIv   = cntFire;
    stb.ivSel    = modeSel;
    stb.is224    = is224Q;
    stb.loadWork = advance && (cyc == '0);
    stb.fetch    = advance && (cyc >= C_FF) && (cyc <= C_LF);
    stb.useExt   = needWord;
    stb.fetchIdx = cycRel[IDX_W-1:0];
    stb.round    = advance && (cyc >= C_FR) && (cyc <= C_LR);
    stb.accum    = advance && (cyc == C_ACC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cyc        <= '0;
      blocksLeft <= '0;
      is224Q     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cntValid) begin
            is224Q     <= modeSel;
            blocksLeft <= cntData;
            cyc        <= '0;
            state      <= (cntData == '0) ? ST_OUT : ST_BLOCK;
          end
        end
        ST_BLOCK: begin
          if (advance) begin
            if (cyc == C_END) begin
              cyc        <= '0;
              blocksLeft <= blocksLeft - 1'b1;
              if (blocksLeft == CNT_W'(1)) state <= ST_OUT;
            end else begin
              cyc <= cyc + 1'b1;
            end
          end
        end
        ST_OUT: begin
          if (digReady) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sha256Core.sv
module sha256Core
  import sha256Pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSel,
  input  logic             cntValid,
  output logic             cntReady,
  input  logic [CNT_W-1:0] cntData,
  input  logic             wordValid,
  output logic             wordReady,
  input  logic [31:0]      wordData,
  output logic             digValid,
  input  logic             digReady,
  output logic [255:0]     digData
);

  ctrlStrobe_t stb;

  sha256Ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .cntValid  (cntValid),
    .cntReady  (cntReady),
    .cntData   (cntData),
    .wordValid (wordValid),
    .wordReady (wordReady),
    .digValid  (digValid),
    .digReady  (digReady),
    .stb       (stb)
  );

  sha256Datapath uPath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wordData (wordData),
    .digest   (digData)
  );

endmodule

// File: rtl/sha256CoreChk.sv
module sha256CoreChk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeSel,
  input logic             cntValid,
  input logic             cntReady,
  input logic [CNT_W-1:0] cntData,
  input logic             wordValid,
  input logic             wordReady,
  input logic [31:0]      wordData,
  input logic             digValid,
  input logic             digReady,
  input logic [255:0]     digData
);

  logic [CNT_W+3:0] wordsSeen;
  logic [CNT_W-1:0] cntHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordsSeen <= '0;
      cntHeld   <= '0;
    end else if (cntValid && cntReady) begin
      wordsSeen <= '0;
      cntHeld   <= cntData;
    end else if (wordValid && wordReady) begin
      wordsSeen <= wordsSeen + 1'b1;
    end
  end

  assert_idle_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    cntReady |-> (!digValid && !wordReady));

  assert_words_per_msg_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(digValid) |-> (wordsSeen == {cntHeld, 4'b0000}));

  assert_digest_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (digValid && !digReady) |=> (digValid && $stable(digData)));

  assert_idle_after_take_R9: assert property (@(posedge clk) disable iff (!rstN)
    (digValid && digReady) |=> (cntReady && !digValid));

  assert_trunc_lane_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cntValid && cntReady && modeSel && (cntData == '0)) |=> (digData[31:0] == 32'h0));

endmodule

bind sha256Core sha256CoreChk #(.CNT_W(CNT_W)) uChk (.*);

// File: tb/tb_sha256Core.sv
module tb_sha256Core;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int BLK_CYC    = 68;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             modeSel = 1'b0;
  logic             cntValid = 1'b0;
  logic             cntReady;
  logic [CNT_W-1:0] cntData = '0;
  logic             wordValid = 1'b0;
  logic             wordReady;
  logic [31:0]      wordData = '0;
  logic             digValid;
  logic             digReady = 1'b0;
  logic [255:0]     digData;

  int nChecks = 0;
  int nErrors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sha256Core #(.CNT_W(CNT_W)) dut (.*);

  localparam logic [31:0] KT [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };
  localparam logic [31:0] H256 [8] = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                       32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
  localparam logic [31:0] H224 [8] = '{32'hc1059ed8, 32'h367cd507, 32'h3070dd17, 32'hf70e5939,
                                       32'hffc00b31, 32'h68581511, 32'h64f98fa7, 32'hbefa4fa4};

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  // Behavioural hash reference over whole padded blocks
  function automatic logic [255:0] refHash(input bit m224, input logic [31:0] msg [$]);
    logic [31:0] h [8];
    logic [31:0] w [64];
    logic [31:0] a, b, c, d, e, f, g, hh, t1, t2;
    logic [255:0] res;
    for (int i = 0; i < 8; i++) h[i] = m224 ? H224[i] : H256[i];
    for (int blk = 0; blk < msg.size() / 16; blk++) begin
      for (int t = 0; t < 64; t++) begin
        if (t < 16) w[t] = msg[blk*16 + t];
        else w[t] = (rr(w[t-2],17) ^ rr(w[t-2],19) ^ (w[t-2] >> 10)) + w[t-7]
                  + (rr(w[t-15],7) ^ rr(w[t-15],18) ^ (w[t-15] >> 3)) + w[t-16];
      end
      a = h[0]; b = h[1]; c = h[2]; d = h[3]; e = h[4]; f = h[5]; g = h[6]; hh = h[7];
      for (int t = 0; t < 64; t++) begin
        t1 = hh + (rr(e,6) ^ rr(e,11) ^ rr(e,25)) + ((e & f) ^ (~e & g)) + KT[t] + w[t];
        t2 = (rr(a,2) ^ rr(a,13) ^ rr(a,22)) + ((a & b) ^ (a & c) ^ (b & c));
        hh = g; g = f; f = e; e = d + t1; d = c; c = b; b = a; a = t1 + t2;
      end
      h[0] += a; h[1] += b; h[2] += c; h[3] += d; h[4] += e; h[5] += f; h[6] += g; h[7] += hh;
    end
    res = {h[0], h[1], h[2], h[3], h[4], h[5], h[6], h[7]};
    if (m224) res[31:0] = 32'h0;
    return res;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
  endtask

  // Runs one message: gaps inserts word bubbles, hold delays digReady,
  // flip toggles modeSel after the count handshake.
  task automatic runMsg(input bit m224, input logic [31:0] words [$], input bit gaps,
                        input int hold, input bit flip, input string req,
                        output logic [255:0] got);
    logic [31:0] q [$];
    logic [255:0] expD, firstD;
    int nBlk, e, holdLeft, accepted;
    bit wFire, dFire, done, seen, expWr;
    q = words;
    nBlk = words.size() / 16;
    expD = refHash(m224, words);
    got = '0;
    @(negedge clk);
    modeSel  = m224;
    cntData  = CNT_W'(nBlk);
    cntValid = 1'b1;
    check(cntReady == 1'b1, "R2 idle before token", 256'(cntReady), 256'(1));
    @(negedge clk);
    cntValid = 1'b0;
    if (flip) modeSel = ~m224;
    e = 0; holdLeft = hold; done = 0; seen = 0; wFire = 0; accepted = 0;
    while (!done && e < 50000) begin
      if (wFire) begin void'(q.pop_front()); accepted++; end
      check(cntReady == 1'b0, "R2 busy", 256'(cntReady), 256'(0));
      if (!gaps) begin
        expWr = (e < BLK_CYC*nBlk) && ((e % BLK_CYC) >= 1) && ((e % BLK_CYC) <= 16);
        check(wordReady == expWr, "R7 wordReady window", 256'(wordReady), 256'(expWr));
        check(digValid == (e >= BLK_CYC*nBlk), "R7 digest timing", 256'(digValid), 256'(e >= BLK_CYC*nBlk));
      end else if (e < BLK_CYC*nBlk) begin
        check(digValid == 1'b0, "R8 no early digest", 256'(digValid), 256'(0));
      end
      if (digValid) begin
        if (!seen) begin
          seen = 1; firstD = digData; got = digData;
          check(digData == expD, req, digData, expD);
          check(accepted == 16*nBlk, "R6 words accepted", 256'(accepted), 256'(16*nBlk));
        end else begin
          check(digData == firstD, "R9 digest held", digData, firstD);
        end
      end
      wordValid = (q.size() > 0) && !(gaps && (e % 3 == 1));
      wordData  = (q.size() > 0) ? q[0] : 32'h0;
      digReady  = digValid && (holdLeft == 0);
      if (digValid && holdLeft > 0) holdLeft--;
      wFire = wordValid && wordReady;
      dFire = digReady && digValid;
      @(negedge clk);
      if (dFire) done = 1;
      e++;
    end
    wordValid = 1'b0;
    digReady  = 1'b0;
    check(done, "R9 digest taken", 256'(done), 256'(1));
    check(digValid == 1'b0 && cntReady == 1'b1, "R9 back to idle", {digValid, cntReady}, 256'b01);
  endtask

  function automatic void randWords(ref logic [31:0] q [$], input int nBlk);
    q = {};
    for (int i = 0; i < 16*nBlk; i++) q.push_back($urandom());
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] abc [$];
    logic [31:0] rnd [$];
    logic [31:0] none [$];
    logic [255:0] d1, d2, dz;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cntReady == 1'b1, "R1 cntReady", 256'(cntReady), 256'(1));
    check(wordReady == 1'b0, "R1 wordReady", 256'(wordReady), 256'(0));
    check(digValid == 1'b0, "R1 digValid", 256'(digValid), 256'(0));
    check(digData == '0, "R1 digData", digData, '0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(cntReady == 1'b1 && digValid == 1'b0, "R1 after release", {cntReady, digValid}, 256'b10);

    abc = {32'h61626380};
    for (int i = 1; i < 15; i++) abc.push_back(32'h0);
    abc.push_back(32'h00000018);
    // Anchor the reference model on known answers
    check(refHash(0, abc) == 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad,
          "R3 reference anchor", refHash(0, abc), 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);
    check(refHash(1, abc) == {224'h23097d223405d8228642a477bda255b32aadbce4bda0b3f7e36c9da7, 32'h0},
          "R4 reference anchor", refHash(1, abc), {224'h23097d223405d8228642a477bda255b32aadbce4bda0b3f7e36c9da7, 32'h0});

    // R3 one block SHA-256, gap-free, R7 timing
    runMsg(0, abc, 0, 0, 0, "R3 single block SHA-256", d1);
    // R4 one block SHA-224
    runMsg(1, abc, 0, 2, 0, "R4 single block SHA-224", d2);
    check(d2[31:0] == 32'h0, "R4 low lane zero", d2, {d2[255:32], 32'h0});
    // R11: same message after a 224 message gives the same SHA-256 digest
    runMsg(0, abc, 0, 0, 0, "R11 repeat digest", d2);
    check(d2 == d1, "R11 state reloaded", d2, d1);
    // R3/R7/R9: three blocks, consumer holds off
    randWords(rnd, 3);
    runMsg(0, rnd, 0, 4, 0, "R3 three block SHA-256", d2);
    // R4/R5/R8: two blocks SHA-224 with bubbles and mode flipped mid message
    randWords(rnd, 2);
    runMsg(1, rnd, 1, 1, 1, "R5 mode held through flip", d2);
    // R5/R8: SHA-256 with bubbles and flip
    randWords(rnd, 2);
    runMsg(0, rnd, 1, 0, 1, "R8 stalled SHA-256", d2);
    // R10: zero-block messages give the initial value
    none = {};
    runMsg(0, none, 0, 0, 0, "R10 zero count SHA-256", dz);
    check(dz == {H256[0], H256[1], H256[2], H256[3], H256[4], H256[5], H256[6], H256[7]},
          "R10 IV 256", dz, {H256[0], H256[1], H256[2], H256[3], H256[4], H256[5], H256[6], H256[7]});
    runMsg(1, none, 0, 3, 0, "R10 zero count SHA-224", dz);
    check(dz == {H224[0], H224[1], H224[2], H224[3], H224[4], H224[5], H224[6], 32'h0},
          "R10 IV 224", dz, {H224[0], H224[1], H224[2], H224[3], H224[4], H224[5], H224[6], 32'h0});

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule